// File: doc/BRIEF.md
# Layered Offset Min-Sum QC-LDPC Decoder

This block decodes one 256-bit quasi-cyclic LDPC codeword. The parity-check matrix is built from a base grid of 7 layers by 8 column blocks, each entry being either an empty block or a 32x32 cyclically shifted identity. That gives 224 checks over 256 code bits, of which the first 32 carry information. Channel reliabilities arrive as one 6-bit signed LLR per code bit. They are written through a simple indexed load port while the decoder is idle. A start pulse then launches decoding with a per-run iteration limit and an optional early stop.

Decoding follows a layered schedule: checks are visited one per cycle, layer after layer. Each visit subtracts the check's previous message from the posterior of every connected bit, forms offset min-sum messages and adds them back. After each full pass over all layers, a syndrome pass counts the unsatisfied checks on the current hard decisions. The run ends when that count is zero (if early stop is on) or when the limit is reached. The hard-decided information bits, the syndrome weight and the number of iterations performed are then presented on registered outputs.

Top module: `ldpc_decoder`

## Requirements
- R1: After reset, busy and done are 0 and info_bits, synd_weight and iter_count are all zero.
- R2: While idle, llr_we stores llr_val (6-bit two's complement) as the channel LLR of code bit llr_addr. A start pulse while idle makes busy read 1 from the next cycle.
- R3: Check r (0..31) of layer l connects to code bit b*32 + ((r + s) mod 32) for every column block b whose shift s is 0 or more; a shift of -1 marks an empty block that adds no connection. The syndrome weight is the number of checks whose connected hard bits have odd parity, so a single wrong bit in a block column with k non-empty blocks yields weight k.
- R4: A code bit decides to 1 when its posterior LLR is negative and to 0 otherwise; info_bits[i] is the decision on code bit i for i in 0..31.
- R5: The message from a check to a bit has magnitude max(m-1, 0), where m is the smallest posterior magnitude among the check's other bits. Its sign is the XOR of those bits' signs. Hence, when every LLR has magnitude 1, all messages are zero and the decisions keep the input signs for the whole run.
- R6: A noise-free codeword with early stop enabled ends after exactly 1 iteration with syndrome weight 0; this holds for both the all-zero and the all-one word under the default shift table.
- R7: With early stop on, a single weak wrong bit among strong correct LLRs is corrected: decoded bits are correct and the syndrome weight is 0.
- R8: With early stop off, the run always performs exactly the effective iteration limit, even when the syndrome is already zero.
- R9: When the syndrome never reaches zero, decoding stops at the effective limit. Busy then clears and the nonzero syndrome weight is reported.
- R10: The 5-bit max_iter field gives the effective limit; 0 is treated as 1 and values above 30 are treated as 30.
- R11: Posteriors and messages from an earlier run do not affect a later one once all LLRs are reloaded, because stored check messages count as zero in the first iteration of every run.
- R12: done is a single-cycle pulse in the cycle busy falls; info_bits, synd_weight and iter_count change only with done and hold afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| llr_we | input | 1 | Write strobe for one channel LLR (honoured while idle) |
| llr_addr | input | 8 | Code bit index of the written LLR |
| llr_val | input | 6 | Signed channel LLR |
| start | input | 1 | Begin decoding (honoured while idle) |
| max_iter | input | 5 | Requested iteration limit, sampled at start |
| early_term | input | 1 | Stop as soon as the syndrome is zero, sampled at start |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle pulse at the end of a decode |
| info_bits | output | 32 | Hard decisions on code bits 0..31 |
| synd_weight | output | 8 | Unsatisfied check count after the last iteration |
| iter_count | output | 5 | Iterations performed in the last decode |

## Verification
The hardest case to reach from the ports is a decode that runs all the way to its limit with a known nonzero syndrome. Ordinary noisy inputs converge after a path that can only be predicted by re-running min-sum. The stimulus uses the offset's dead zone instead: every LLR is set to magnitude 1 with one bit negated. All messages then stay at zero, so the decisions never move and the syndrome weight equals the number of non-empty blocks in that bit's column. This fixed point drives the limit, the clamping of max_iter, the skipping of empty blocks and the run that follows without any model of the message arithmetic.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;

  // Controller states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_SYND,
    ST_EVAL
  } dec_state_t;

  // Default circulant shifts, one row per layer; -1 marks an empty block.
  // Every layer holds six blocks, so each check has even degree.
  localparam int DEF_SHIFT [7][8] = '{
    '{-1, -1,  5, 17,  9, 26,  2, 14},
    '{11, -1, -1,  3, 20,  8, 29,  6},
    '{23,  4, -1, -1, 15, 31, 10, 19},
    '{ 7, 28, 13, -1, -1, 21,  1, 25},
    '{18,  9, 30, 12, -1, -1, 24,  3},
    '{ 2, 16,  6, 27, 11, -1, -1, 22},
    '{29, 12, 20,  8,  4, 17, -1, -1}
  };

endpackage

// File: rtl/ldpc_cmem.sv
// Per-check compressed message store: simple dual port, synchronous read.
module ldpc_cmem #(
  parameter int DEPTH = 224,
  parameter int W     = 21,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ldpc_map.sv
// Maps a check number to the code bits it touches.
module ldpc_map #(
  parameter int Z  = 32,
  parameter int MB = 7,
  parameter int NB = 8,
  parameter int SHIFT [MB][NB] = ldpc_pkg::DEF_SHIFT,
  localparam int ZW = $clog2(Z),
  localparam int CW = $clog2(MB*Z),
  localparam int AW = $clog2(NB*Z)
) (
  input  logic [CW-1:0]          chk,
  output logic [NB-1:0]          act,
  output logic [NB-1:0][AW-1:0]  vidx
);
  always_comb begin
    int lay;
    logic [ZW-1:0] row;
    logic [ZW-1:0] off;
    logic [ZW-1:0] col;
    lay = int'(chk) / Z;
    row = chk[ZW-1:0];
    for (int b = 0; b < NB; b++) begin
      act[b] = 1'b0;
      off    = '0;
      for (int l = 0; l < MB; l++) begin
        if (lay == l) begin
          act[b] = (SHIFT[l][b] >= 0);
          off    = ZW'(SHIFT[l][b]);
        end
      end
      col     = row + off;
      vidx[b] = AW'(b * Z) + AW'(col);
    end
  end
endmodule

// File: rtl/ldpc_cnu.sv
// One check-node update: remove old message, offset min-sum, add new message.
module ldpc_cnu #(
  parameter int NB  = 8,
  parameter int P_W = 8,
  parameter int M_W = 5,
  localparam int BW = $clog2(NB)
) (
  input  logic                    first,
  input  logic [NB-1:0]           act,
  input  logic [NB-1:0][P_W-1:0]  p_in,
  input  logic [M_W-1:0]          r1_in,
  input  logic [M_W-1:0]          r2_in,
  input  logic [BW-1:0]           idx_in,
  input  logic [NB-1:0]           sgn_in,
  output logic [NB-1:0][P_W-1:0]  p_out,
  output logic [M_W-1:0]          r1_out,
  output logic [M_W-1:0]          r2_out,
  output logic [BW-1:0]           idx_out,
  output logic [NB-1:0]           sgn_out
);
  localparam int PMAX = 2**(P_W-1) - 1;
  localparam int PMIN = -(2**(P_W-1));
  localparam logic [P_W-1:0] PMAX_V = {1'b0, {(P_W-1){1'b1}}};
  localparam logic [P_W-1:0] PMIN_V = {1'b1, {(P_W-1){1'b0}}};
  localparam logic [P_W:0]   MMAX_V = {{(P_W+1-M_W){1'b0}}, {M_W{1'b1}}};

  function automatic logic [P_W-1:0] sat_p(input logic signed [P_W+1:0] v);
    if (v > PMAX) return PMAX_V;
    if (v < PMIN) return PMIN_V;
    return v[P_W-1:0];
  endfunction

  function automatic logic [M_W-1:0] offset_mag(input logic [P_W:0] m);
    logic [P_W:0] d;
    d = m - 1'b1;
    if (m == '0) return '0;
    if (d > MMAX_V) return '1;
    return d[M_W-1:0];
  endfunction

  logic [NB-1:0][P_W-1:0] q;
  logic [NB-1:0][P_W:0]   mag;
  logic [P_W:0]           m1, m2;
  logic [BW-1:0]          ix;
  logic                   tot;

  always_comb begin
    logic [M_W-1:0]        rmag;
    logic signed [P_W+1:0] rv, rold, pe;
    for (int j = 0; j < NB; j++) begin
      rmag = (BW'(j) == idx_in) ? r2_in : r1_in;
      rv   = {{(P_W+2-M_W){1'b0}}, rmag};
      rold = first ? '0 : (sgn_in[j] ? -rv : rv);
      pe   = {{2{p_in[j][P_W-1]}}, p_in[j]};
      q[j] = sat_p(pe - rold);
      mag[j] = q[j][P_W-1] ? ({1'b0, ~q[j]} + 1'b1) : {1'b0, q[j]};
    end
  end

  always_comb begin
    m1  = '1;
    m2  = '1;
    ix  = '0;
    tot = 1'b0;
    for (int j = 0; j < NB; j++) begin
      if (act[j]) begin
        tot = tot ^ q[j][P_W-1];
        if (mag[j] < m1) begin
          m2 = m1;
          m1 = mag[j];
          ix = BW'(j);
        end else if (mag[j] < m2) begin
          m2 = mag[j];
        end
      end
    end
  end

  assign r1_out  = offset_mag(m1);
  assign r2_out  = offset_mag(m2);
  assign idx_out = ix;

  always_comb begin
    logic [M_W-1:0]        rm;
    logic signed [P_W+1:0] rn, qe;
    for (int j = 0; j < NB; j++) begin
      sgn_out[j] = act[j] & (tot ^ q[j][P_W-1]);
      rm  = (BW'(j) == ix) ? r2_out : r1_out;
      rn  = {{(P_W+2-M_W){1'b0}}, rm};
      if (sgn_out[j]) rn = -rn;
      qe  = {{2{q[j][P_W-1]}}, q[j]};
      p_out[j] = act[j] ? sat_p(qe + rn) : p_in[j];
    end
  end
endmodule

// File: rtl/ldpc_decoder.sv
module ldpc_decoder #(
  parameter int Z        = 32,
  parameter int MB       = 7,
  parameter int NB       = 8,
  parameter int LLR_W    = 6,
  parameter int P_W      = 8,
  parameter int MAX_ITER = 30,
  parameter int INFO_W   = 32,
  parameter int SHIFT [MB][NB] = ldpc_pkg::DEF_SHIFT,
  localparam int N    = NB * Z,
  localparam int NCHK = MB * Z,
  localparam int AW   = $clog2(N),
  localparam int CW   = $clog2(NCHK),
  localparam int BW   = $clog2(NB),
  localparam int M_W  = LLR_W - 1,
  localparam int IW   = $clog2(MAX_ITER + 1),
  localparam int SWW  = $clog2(NCHK + 1),
  localparam int SW_W = 2*M_W + BW + NB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              llr_we,
  input  logic [AW-1:0]     llr_addr,
  input  logic [LLR_W-1:0]  llr_val,
  input  logic              start,
  input  logic [IW-1:0]     max_iter,
  input  logic              early_term,
  output logic              busy,
  output logic              done,
  output logic [INFO_W-1:0] info_bits,
  output logic [SWW-1:0]    synd_weight,
  output logic [IW-1:0]     iter_count
);
  import ldpc_pkg::*;

  dec_state_t      st;
  logic [CW-1:0]   cnt, s1_cnt, map_chk;
  logic            s1_v;
  logic [IW-1:0]   iter_q, lim_q, lim_eff, iter_inc;
  logic            et_q;
  logic [SWW-1:0]  sw_acc;

  logic [P_W-1:0]  p_mem [N];

  logic [NB-1:0]            act;
  logic [NB-1:0][AW-1:0]    vidx;
  logic [NB-1:0][P_W-1:0]   p_rd, p_new;
  logic [SW_W-1:0]          st_rd, st_wr;
  logic [M_W-1:0]           r1_n, r2_n;
  logic [BW-1:0]            idx_n;
  logic [NB-1:0]            sgn_n;
  logic                     par;
  logic [INFO_W-1:0]        hard_info;

  // Effective limit: 0 -> 1, above MAX_ITER -> MAX_ITER
  always_comb begin
    if (max_iter == '0)                  lim_eff = IW'(1);
    else if (max_iter > IW'(MAX_ITER))   lim_eff = IW'(MAX_ITER);
    else                                 lim_eff = max_iter;
  end

  assign iter_inc = iter_q + 1'b1;
  assign map_chk  = (st == ST_SYND) ? cnt : s1_cnt;

  ldpc_map #(.Z(Z), .MB(MB), .NB(NB), .SHIFT(SHIFT)) u_map (
    .chk  (map_chk),
    .act  (act),
    .vidx (vidx)
  );

  ldpc_cmem #(.DEPTH(NCHK), .W(SW_W)) u_cmem (
    .clk   (clk),
    .we    (s1_v),
    .waddr (s1_cnt),
    .wdata (st_wr),
    .raddr (cnt),
    .rdata (st_rd)
  );

  always_comb begin
    for (int b = 0; b < NB; b++) p_rd[b] = p_mem[vidx[b]];
  end

  ldpc_cnu #(.NB(NB), .P_W(P_W), .M_W(M_W)) u_cnu (
    .first   (iter_q == '0),
    .act     (act),
    .p_in    (p_rd),
    .r1_in   (st_rd[SW_W-1 -: M_W]),
    .r2_in   (st_rd[SW_W-M_W-1 -: M_W]),
    .idx_in  (st_rd[NB+BW-1 -: BW]),
    .sgn_in  (st_rd[NB-1:0]),
    .p_out   (p_new),
    .r1_out  (r1_n),
    .r2_out  (r2_n),
    .idx_out (idx_n),
    .sgn_out (sgn_n)
  );

  assign st_wr = {r1_n, r2_n, idx_n, sgn_n};

  always_comb begin
    par = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (act[b]) par = par ^ p_rd[b][P_W-1];
    end
  end

  always_comb begin
    for (int i = 0; i < INFO_W; i++) hard_info[i] = p_mem[i][P_W-1];
  end

  // Posterior store: channel load while idle, layer writes while running
  always_ff @(posedge clk) begin
    if (llr_we && st == ST_IDLE)
      p_mem[llr_addr] <= {{(P_W-LLR_W){llr_val[LLR_W-1]}}, llr_val};
    if (s1_v) begin
      for (int b = 0; b < NB; b++) begin
        if (act[b]) p_mem[vidx[b]] <= p_new[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      s1_cnt      <= '0;
      s1_v        <= 1'b0;
      iter_q      <= '0;
      lim_q       <= '0;
      et_q        <= 1'b0;
      sw_acc      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      info_bits   <= '0;
      synd_weight <= '0;
      iter_count  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            lim_q  <= lim_eff;
            et_q   <= early_term;
            iter_q <= '0;
            cnt    <= '0;
            busy   <= 1'b1;
            st     <= ST_RUN;
          end
        end
        ST_RUN: begin
          s1_v   <= 1'b1;
          s1_cnt <= cnt;
          if (cnt == CW'(NCHK-1)) st <= ST_DRAIN;
          else                    cnt <= cnt + 1'b1;
        end
        ST_DRAIN: begin
          s1_v   <= 1'b0;
          cnt    <= '0;
          sw_acc <= '0;
          st     <= ST_SYND;
        end
        ST_SYND: begin
          sw_acc <= sw_acc + {{(SWW-1){1'b0}}, par};
          if (cnt == CW'(NCHK-1)) st <= ST_EVAL;
          else                    cnt <= cnt + 1'b1;
        end
        ST_EVAL: begin
          iter_q <= iter_inc;
          cnt    <= '0;
          if ((et_q && sw_acc == '0) || iter_inc == lim_q) begin
            busy        <= 1'b0;
            done        <= 1'b1;
            info_bits   <= hard_info;
            synd_weight <= sw_acc;
            iter_count  <= iter_inc;
            st          <= ST_IDLE;
          end else begin
            st <= ST_RUN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_decoder_chk.sv
module ldpc_decoder_chk #(
  parameter int IW       = 5,
  parameter int SWW      = 8,
  parameter int MAX_ITER = 30
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [IW-1:0]  max_iter,
  input logic           early_term,
  input logic           busy,
  input logic           done,
  input logic [SWW-1:0] synd_weight,
  input logic [IW-1:0]  iter_count
);
  logic [IW-1:0] lim_c;
  logic          et_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_c <= '0;
      et_c  <= 1'b0;
    end else if (start && !busy) begin
      if (max_iter == '0)                lim_c <= IW'(1);
      else if (int'(max_iter) > MAX_ITER) lim_c <= IW'(MAX_ITER);
      else                               lim_c <= max_iter;
      et_c <= early_term;
    end
  end

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r12_done_at_busy_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_results_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(synd_weight) && $stable(iter_count)));

  a_r9_nonzero_hits_limit: assert property (@(posedge clk) disable iff (rst)
    (done && synd_weight != '0) |-> (iter_count == lim_c));

  a_r8_early_only_clean: assert property (@(posedge clk) disable iff (rst)
    (done && iter_count != lim_c) |-> (synd_weight == '0 && et_c));

  a_r10_iter_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (iter_count >= IW'(1) && int'(iter_count) <= MAX_ITER));
endmodule

bind ldpc_decoder ldpc_decoder_chk #(.IW(IW), .SWW(SWW), .MAX_ITER(MAX_ITER)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .max_iter    (max_iter),
  .early_term  (early_term),
  .busy        (busy),
  .done        (done),
  .synd_weight (synd_weight),
  .iter_count  (iter_count)
);

// File: tb/ldpc_decoder_tb.sv
module ldpc_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        llr_we;
  logic [7:0]  llr_addr;
  logic [5:0]  llr_val;
  logic        start;
  logic [4:0]  max_iter;
  logic        early_term;
  logic        busy, done;
  logic [31:0] info_bits;
  logic [7:0]  synd_weight;
  logic [4:0]  iter_count;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] r_info;
  int          r_sw, r_it;

  always #2 clk = ~clk;

  ldpc_decoder u_dut (
    .clk(clk), .rst(rst), .llr_we(llr_we), .llr_addr(llr_addr), .llr_val(llr_val),
    .start(start), .max_iter(max_iter), .early_term(early_term),
    .busy(busy), .done(done), .info_bits(info_bits),
    .synd_weight(synd_weight), .iter_count(iter_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int col_degree(input int b);
    int c = 0;
    for (int l = 0; l < 7; l++) if (ldpc_pkg::DEF_SHIFT[l][b] >= 0) c++;
    return c;
  endfunction

  task automatic load_one(input int addr, input int val);
    @(negedge clk);
    llr_we = 1'b1; llr_addr = 8'(addr); llr_val = 6'(val);
    @(negedge clk);
    llr_we = 1'b0;
  endtask

  task automatic load_fill(input int val);
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      llr_we = 1'b1; llr_addr = 8'(i); llr_val = 6'(val);
      @(negedge clk);
    end
    llr_we = 1'b0;
  endtask

  task automatic decode(input int lim, input bit et);
    int n = 0;
    @(negedge clk);
    max_iter = 5'(lim); early_term = et; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    while (done !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R9", "decode finished", done, 1);
    chk(busy === 1'b0, "R12", "busy low with done", busy, 0);
    r_info = info_bits; r_sw = synd_weight; r_it = iter_count;
    @(negedge clk);
    chk(done === 1'b0, "R12", "done single cycle", done, 0);
    chk(iter_count == 5'(r_it) && synd_weight == 8'(r_sw), "R12", "results held",
        iter_count, r_it);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    chk(info_bits === '0, "R1", "info after reset", info_bits, 0);
    chk(synd_weight === '0 && iter_count === '0, "R1", "weight/count after reset",
        synd_weight + iter_count, 0);
  endtask

  task automatic t_clean_zero();
    load_fill(31);
    decode(30, 1'b1);
    chk(r_it == 1, "R6", "all-zero iterations", r_it, 1);
    chk(r_sw == 0, "R6", "all-zero syndrome", r_sw, 0);
    chk(r_info == 32'h0, "R4", "all-zero info", r_info, 0);
  endtask

  task automatic t_clean_ones();
    load_fill(-31);
    decode(30, 1'b1);
    chk(r_it == 1, "R6", "all-one iterations", r_it, 1);
    chk(r_sw == 0, "R3", "all-one syndrome (even layer degree)", r_sw, 0);
    chk(r_info == 32'hFFFF_FFFF, "R4", "all-one info", r_info, 32'hFFFF_FFFF);
  endtask

  task automatic t_weak_error();
    load_fill(20);
    load_one(5, -3);
    decode(30, 1'b1);
    chk(r_info == 32'h0, "R7", "info bit error corrected", r_info, 0);
    chk(r_sw == 0, "R7", "syndrome after correction", r_sw, 0);
    load_fill(20);
    load_one(130, -3);
    decode(30, 1'b1);
    chk(r_sw == 0 && r_info == 32'h0, "R7", "parity bit error corrected", r_sw, 0);
  endtask

  task automatic t_no_early_stop();
    load_fill(31);
    decode(4, 1'b0);
    chk(r_it == 4, "R8", "iterations with early stop off", r_it, 4);
    chk(r_sw == 0 && r_info == 32'h0, "R8", "clean result with early stop off", r_sw, 0);
  endtask

  task automatic t_stuck_info();
    load_fill(1);
    load_one(7, -1);
    decode(5, 1'b1);
    chk(r_it == 5, "R9", "stuck run reaches limit", r_it, 5);
    chk(r_sw == col_degree(0), "R3", "stuck weight = column 0 degree", r_sw, col_degree(0));
    chk(r_info == 32'h80, "R5", "decisions keep input signs", r_info, 32'h80);
  endtask

  task automatic t_stuck_parity();
    load_fill(1);
    load_one(40, -1);
    decode(3, 1'b0);
    chk(r_sw == col_degree(1), "R3", "empty blocks skipped in weight", r_sw, col_degree(1));
    chk(r_info == 32'h0 && r_it == 3, "R5", "parity flip leaves info clean", r_it, 3);
  endtask

  task automatic t_limit_clamp();
    load_fill(1);
    load_one(7, -1);
    decode(31, 1'b1);
    chk(r_it == 30, "R10", "limit 31 clamps to 30", r_it, 30);
    decode(0, 1'b1);
    chk(r_it == 1, "R10", "limit 0 acts as 1", r_it, 1);
    chk(r_sw == col_degree(0), "R9", "nonzero weight at limit", r_sw, col_degree(0));
  endtask

  task automatic t_back_to_back();
    load_fill(-20);
    decode(6, 1'b0);
    load_fill(31);
    decode(30, 1'b1);
    chk(r_it == 1 && r_sw == 0, "R11", "clean decode after prior run", r_it, 1);
    chk(r_info == 32'h0, "R11", "no leakage into info", r_info, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    rst = 1'b1; llr_we = 1'b0; llr_addr = '0; llr_val = '0;
    start = 1'b0; max_iter = '0; early_term = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean_zero();
    t_clean_ones();
    t_weak_error();
    t_no_early_stop();
    t_stuck_info();
    t_stuck_parity();
    t_limit_clamp();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule